// File: doc/BRIEF.md
# Two-Domain Software Reset Sequencer

This block turns two software request bits into an ordered reset of a controller core that runs on a bus clock (hclk) and a PHY clock. The light request resets only the bus-side logic. It clears the bus-side control bits and leaves the FIFOs and the pending interrupt flags alone. The heavy request aborts PHY-side activity at once. It resets the PHY domain, flushes every FIFO, clears the interrupt flags and clears every configuration bit except two speed-selection fields.

Before either request pulses any bus-side reset, the block asks the bus master to stop and waits for its idle indication, so a transfer already in flight completes its final data phase. The heavy request travels into the PHY domain as a toggle and comes back as a toggle. Its request bit clears only when the PHY side has acknowledged and the bus-side pulse is over. After that bit clears, a PHY-side guard counter keeps PHY access blocked for at least GUARD_CYC PHY clocks.

Software sees three things in the read word: both request bits and a master-idle flag. Request bits clear themselves.

Top module: `srst_ctrl`

## Requirements
- R1: After reset the read word bits [1:0] are 0, bus_dom_rst, fifo_flush, phy_dom_rst, usb_abort and mst_stop_req are 0, and phy_access_ok is 1.
- R2: A write with ctl_wdata[1]=1 (and bit 0 = 0) sets read bit 1. Once mst_idle is high, bus_dom_rst is asserted for exactly HRST_CYC (default 4) hclk cycles, with no fifo_flush and no phy_dom_rst. After that pulse, read bit 1 returns to 0.
- R3: The bus-only reset clears configuration bits [7:4] and keeps every other configuration bit. It leaves int_q uncleared, so interrupt flags raised while that reset is pending stay visible.
- R4: A write with ctl_wdata[0]=1 asserts bus_dom_rst and fifo_flush together for exactly HRST_CYC hclk cycles. It clears int_q and clears every configuration bit except the clock-select field [1:0] and the speed field [3:2].
- R5: From an accepted request until its bit clears, mst_stop_req is 1. bus_dom_rst and fifo_flush never assert while mst_idle is 0.
- R6: A core request asserts usb_abort and phy_dom_rst without waiting for mst_idle. Read bit 0 clears only after the PHY-side reset has finished and been acknowledged.
- R7: Read bit 31 equals the current mst_idle input.
- R8: phy_access_ok is 0 from the PHY-side reset until at least 3 PHY clocks after read bit 0 clears, and then returns to 1.
- R9: Writing 0 to a request bit has no effect. Writing 1 to either bit while a reset is in progress is ignored, both during and after that reset.
- R10: Writing 1 to both bits at once runs the core reset, and both read bits clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus-domain clock |
| hrst_n | input | 1 | Bus-domain asynchronous reset, active low |
| phy_clk | input | 1 | PHY-domain clock |
| phy_rst_n | input | 1 | PHY-domain asynchronous reset, active low |
| ctl_wr_en | input | 1 | Write strobe for the request bits |
| ctl_wdata | input | 2 | Write data: bit 1 bus-only request, bit 0 core request |
| ctl_rdata | output | 32 | Read word: bit 31 master idle, bits 1:0 pending requests |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | CFG_W | Configuration write data |
| cfg_q | output | CFG_W | Configuration word |
| int_set | input | INT_W | Interrupt event pulses, accumulated into int_q |
| int_q | output | INT_W | Sticky interrupt flags |
| mst_idle | input | 1 | Bus master has no transfer in flight |
| mst_stop_req | output | 1 | Asks the bus master to finish and stay idle |
| bus_dom_rst | output | 1 | Reset pulse for bus-domain state machines |
| fifo_flush | output | 1 | Flush pulse for all transmit and receive FIFOs |
| phy_dom_rst | output | 1 | Reset pulse for the PHY domain (PHY clock) |
| usb_abort | output | 1 | Immediate abort of USB-side activity (PHY clock) |
| phy_access_ok | output | 1 | PHY domain may be accessed (PHY clock) |

## Verification
The hardest cases to reach are a second write that lands while a reset is still draining, and a PHY acknowledge that must arrive before the master goes idle. The bench keeps mst_idle low for a chosen number of cycles after each request. It places a second write, or an interrupt pulse, in the middle of that window. It also checks that the PHY pulse has already happened while bit 0 is still held. Each request's outcome is pushed to a scoreboard and compared when the request bits fall: which bits were pending, the flush and PHY pulses, the pulse length, and the configuration and interrupt words.

// File: rtl/srst_pkg.sv
package srst_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_BUS_WAIT,
      SQ_BUS_HIT,
      SQ_CORE_WAIT,
      SQ_CORE_HIT
   } sq_state_t;

   localparam int REQ_CORE_BIT  = 0;
   localparam int REQ_BUS_BIT   = 1;
   localparam int IDLE_FLAG_BIT = 31;
   localparam int RD_W          = 32;

   localparam int CLKSEL_LSB = 0;
   localparam int CLKSEL_W   = 2;
   localparam int SPEED_LSB  = 2;
   localparam int SPEED_W    = 2;
   localparam int BUSCTL_LSB = 4;
   localparam int BUSCTL_W   = 4;
   localparam int CFG_MIN_W  = BUSCTL_LSB + BUSCTL_W + 1;

endpackage

// File: rtl/srst_sync.sv
module srst_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/srst_hold.sv
module srst_hold
   import srst_pkg::*;
#(
   parameter int CFG_W = 16,
   parameter int INT_W = 8
) (
   input  logic             hclk,
   input  logic             hrst_n,
   input  logic             cfg_wr_en,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic [INT_W-1:0] int_set,
   input  logic             bus_clr,
   input  logic             core_clr,
   input  logic             int_clr,
   output logic [CFG_W-1:0] cfg_q,
   output logic [INT_W-1:0] int_q
);

   generate
      if (CFG_W < CFG_MIN_W) begin : g_bad_cfg
         $error("srst_hold: CFG_W too small for the field layout");
      end
      if (INT_W < 1) begin : g_bad_int
         $error("srst_hold: INT_W must be positive");
      end
   endgenerate

   localparam logic [CFG_W-1:0] KEEP_MASK =
      ((CFG_W'(1) << (CLKSEL_LSB + CLKSEL_W)) - CFG_W'(1)) |
      (((CFG_W'(1) << SPEED_W) - CFG_W'(1)) << SPEED_LSB);
   localparam logic [CFG_W-1:0] BUSCTL_MASK =
      ((CFG_W'(1) << BUSCTL_W) - CFG_W'(1)) << BUSCTL_LSB;

   always_ff @(posedge hclk or negedge hrst_n) begin
      if (!hrst_n) begin
         cfg_q <= '0;
      end else if (core_clr) begin
         cfg_q <= cfg_q & KEEP_MASK;
      end else if (bus_clr) begin
         cfg_q <= cfg_q & ~BUSCTL_MASK;
      end else if (cfg_wr_en) begin
         cfg_q <= cfg_wdata;
      end
   end

   always_ff @(posedge hclk or negedge hrst_n) begin
      if (!hrst_n)      int_q <= '0;
      else if (int_clr) int_q <= '0;
      else              int_q <= int_q | int_set;
   end

   // R4: speed fields survive any reset pulse
   a_r4_keep_speed: assert property (@(posedge hclk) disable iff (!hrst_n)
      (bus_clr || core_clr) |=> ((cfg_q & KEEP_MASK) == ($past(cfg_q) & KEEP_MASK)));

   // R3: bus-only reset drops no interrupt flag
   a_r3_int_kept: assert property (@(posedge hclk) disable iff (!hrst_n)
      (bus_clr && !int_clr) |=> ((int_q & $past(int_q)) == $past(int_q)));

endmodule

// File: rtl/srst_phy_side.sv
module srst_phy_side #(
   parameter int PHY_RST_CYC = 4,
   parameter int GUARD_CYC   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic phy_clk,
   input  logic phy_rst_n,
   input  logic req_tgl_h,
   input  logic done_tgl_h,
   output logic ack_tgl,
   output logic phy_dom_rst,
   output logic usb_abort,
   output logic phy_access_ok
);

   generate
      if (PHY_RST_CYC < 1) begin : g_bad_rst
         $error("srst_phy_side: PHY_RST_CYC must be positive");
      end
      if (GUARD_CYC < 3) begin : g_bad_guard
         $error("srst_phy_side: GUARD_CYC must be at least 3");
      end
   endgenerate

   localparam int RW = $clog2(PHY_RST_CYC + 1);
   localparam int GW = $clog2(GUARD_CYC + 1);

   logic req_s, done_s, req_d, done_d;
   logic req_edge, done_edge;
   logic [RW-1:0] rst_cnt;
   logic [GW-1:0] g_cnt;
   logic          guard_on;

   srst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
      .clk(phy_clk), .rst_n(phy_rst_n), .d(req_tgl_h), .q(req_s));

   srst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
      .clk(phy_clk), .rst_n(phy_rst_n), .d(done_tgl_h), .q(done_s));

   assign req_edge  = req_s ^ req_d;
   assign done_edge = done_s ^ done_d;

   always_ff @(posedge phy_clk or negedge phy_rst_n) begin
      if (!phy_rst_n) begin
         req_d         <= 1'b0;
         done_d        <= 1'b0;
         phy_dom_rst   <= 1'b0;
         rst_cnt       <= '0;
         ack_tgl       <= 1'b0;
         guard_on      <= 1'b0;
         g_cnt         <= '0;
         phy_access_ok <= 1'b1;
      end else begin
         req_d  <= req_s;
         done_d <= done_s;
         if (req_edge) begin
            phy_dom_rst   <= 1'b1;
            rst_cnt       <= '0;
            phy_access_ok <= 1'b0;
            guard_on      <= 1'b0;
         end else if (phy_dom_rst) begin
            if (rst_cnt == RW'(PHY_RST_CYC - 1)) begin
               phy_dom_rst <= 1'b0;
               ack_tgl     <= ~ack_tgl;
            end else begin
               rst_cnt <= rst_cnt + 1'b1;
            end
         end
         if (done_edge) begin
            guard_on <= 1'b1;
            g_cnt    <= '0;
         end else if (guard_on) begin
            if (g_cnt == GW'(GUARD_CYC - 1)) begin
               guard_on      <= 1'b0;
               phy_access_ok <= 1'b1;
            end else begin
               g_cnt <= g_cnt + 1'b1;
            end
         end
      end
   end

   assign usb_abort = req_edge | phy_dom_rst;

   // R8: no PHY access while the PHY domain is held
   a_r8_ok_low_in_rst: assert property (@(posedge phy_clk) disable iff (!phy_rst_n)
      phy_dom_rst |-> !phy_access_ok);

   // R8: access reopens only at the end of the guard count
   a_r8_ok_after_guard: assert property (@(posedge phy_clk) disable iff (!phy_rst_n)
      $rose(phy_access_ok) |-> $past(guard_on));

   // R6: acknowledge only once the PHY pulse has run
   a_r6_ack_after_rst: assert property (@(posedge phy_clk) disable iff (!phy_rst_n)
      (ack_tgl != $past(ack_tgl)) |-> $past(phy_dom_rst));

endmodule

// File: rtl/srst_seq.sv
module srst_seq
   import srst_pkg::*;
#(
   parameter int HRST_CYC    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic hclk,
   input  logic hrst_n,
   input  logic wr_en,
   input  logic wr_bus,
   input  logic wr_core,
   input  logic mst_idle,
   input  logic ack_tgl_p,
   output logic req_bus_q,
   output logic req_core_q,
   output logic req_tgl,
   output logic done_tgl,
   output logic mst_stop_req,
   output logic bus_dom_rst,
   output logic core_hit
);

   generate
      if (HRST_CYC < 1) begin : g_bad_hrst
         $error("srst_seq: HRST_CYC must be positive");
      end
   endgenerate

   localparam int HW = $clog2(HRST_CYC + 1);

   sq_state_t     state;
   logic [HW-1:0] hit_cnt;
   logic          ack_s, ack_d, ack_edge, ack_seen;

   srst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
      .clk(hclk), .rst_n(hrst_n), .d(ack_tgl_p), .q(ack_s));

   assign ack_edge = ack_s ^ ack_d;

   always_ff @(posedge hclk or negedge hrst_n) begin
      if (!hrst_n) begin
         state      <= SQ_IDLE;
         hit_cnt    <= '0;
         ack_d      <= 1'b0;
         ack_seen   <= 1'b0;
         req_bus_q  <= 1'b0;
         req_core_q <= 1'b0;
         req_tgl    <= 1'b0;
         done_tgl   <= 1'b0;
      end else begin
         ack_d <= ack_s;
         case (state)
            SQ_IDLE: begin
               if (wr_en && wr_core) begin
                  req_core_q <= 1'b1;
                  req_bus_q  <= wr_bus;
                  req_tgl    <= ~req_tgl;
                  ack_seen   <= 1'b0;
                  state      <= SQ_CORE_WAIT;
               end else if (wr_en && wr_bus) begin
                  req_bus_q <= 1'b1;
                  state     <= SQ_BUS_WAIT;
               end
            end
            SQ_BUS_WAIT: begin
               if (mst_idle) begin
                  hit_cnt <= '0;
                  state   <= SQ_BUS_HIT;
               end
            end
            SQ_BUS_HIT: begin
               if (hit_cnt == HW'(HRST_CYC - 1)) begin
                  req_bus_q <= 1'b0;
                  state     <= SQ_IDLE;
               end else begin
                  hit_cnt <= hit_cnt + 1'b1;
               end
            end
            SQ_CORE_WAIT: begin
               if (ack_edge) ack_seen <= 1'b1;
               if (mst_idle && (ack_seen || ack_edge)) begin
                  hit_cnt <= '0;
                  state   <= SQ_CORE_HIT;
               end
            end
            SQ_CORE_HIT: begin
               if (hit_cnt == HW'(HRST_CYC - 1)) begin
                  req_core_q <= 1'b0;
                  req_bus_q  <= 1'b0;
                  done_tgl   <= ~done_tgl;
                  state      <= SQ_IDLE;
               end else begin
                  hit_cnt <= hit_cnt + 1'b1;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign mst_stop_req = (state != SQ_IDLE);
   assign bus_dom_rst  = (state == SQ_BUS_HIT) || (state == SQ_CORE_HIT);
   assign core_hit     = (state == SQ_CORE_HIT);

   // R6: core bit falls only out of the pulse phase
   a_r6_core_clear_in_hit: assert property (@(posedge hclk) disable iff (!hrst_n)
      $fell(req_core_q) |-> ($past(state) == SQ_CORE_HIT));

   // R10: core completion leaves no bus request behind
   a_r10_clear_together: assert property (@(posedge hclk) disable iff (!hrst_n)
      $fell(req_core_q) |-> !req_bus_q);

   // R2: a bus-only request never flushes
   a_r2_no_flush_bus_only: assert property (@(posedge hclk) disable iff (!hrst_n)
      (req_bus_q && !req_core_q) |-> !core_hit);

   // R5: request pending means the master is held off
   a_r5_stop_while_pending: assert property (@(posedge hclk) disable iff (!hrst_n)
      (req_bus_q || req_core_q) |-> mst_stop_req);

   // R9: a new core request is never taken mid-reset
   a_r9_no_restart: assert property (@(posedge hclk) disable iff (!hrst_n)
      ($past(mst_stop_req) && !$past(req_core_q)) |-> !req_core_q);

endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
   import srst_pkg::*;
#(
   parameter int CFG_W       = 16,
   parameter int INT_W       = 8,
   parameter int HRST_CYC    = 4,
   parameter int PHY_RST_CYC = 4,
   parameter int GUARD_CYC   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             hclk,
   input  logic             hrst_n,
   input  logic             phy_clk,
   input  logic             phy_rst_n,
   input  logic             ctl_wr_en,
   input  logic [1:0]       ctl_wdata,
   output logic [31:0]      ctl_rdata,
   input  logic             cfg_wr_en,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_q,
   input  logic [INT_W-1:0] int_set,
   output logic [INT_W-1:0] int_q,
   input  logic             mst_idle,
   output logic             mst_stop_req,
   output logic             bus_dom_rst,
   output logic             fifo_flush,
   output logic             phy_dom_rst,
   output logic             usb_abort,
   output logic             phy_access_ok
);

   logic req_bus_q, req_core_q, req_tgl, done_tgl, ack_tgl, core_hit;

   srst_seq #(.HRST_CYC(HRST_CYC), .SYNC_STAGES(SYNC_STAGES)) u_seq (
      .hclk         (hclk),
      .hrst_n       (hrst_n),
      .wr_en        (ctl_wr_en),
      .wr_bus       (ctl_wdata[REQ_BUS_BIT]),
      .wr_core      (ctl_wdata[REQ_CORE_BIT]),
      .mst_idle     (mst_idle),
      .ack_tgl_p    (ack_tgl),
      .req_bus_q    (req_bus_q),
      .req_core_q   (req_core_q),
      .req_tgl      (req_tgl),
      .done_tgl     (done_tgl),
      .mst_stop_req (mst_stop_req),
      .bus_dom_rst  (bus_dom_rst),
      .core_hit     (core_hit)
   );

   srst_phy_side #(
      .PHY_RST_CYC (PHY_RST_CYC),
      .GUARD_CYC   (GUARD_CYC),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_phy (
      .phy_clk       (phy_clk),
      .phy_rst_n     (phy_rst_n),
      .req_tgl_h     (req_tgl),
      .done_tgl_h    (done_tgl),
      .ack_tgl       (ack_tgl),
      .phy_dom_rst   (phy_dom_rst),
      .usb_abort     (usb_abort),
      .phy_access_ok (phy_access_ok)
   );

   srst_hold #(.CFG_W(CFG_W), .INT_W(INT_W)) u_hold (
      .hclk      (hclk),
      .hrst_n    (hrst_n),
      .cfg_wr_en (cfg_wr_en),
      .cfg_wdata (cfg_wdata),
      .int_set   (int_set),
      .bus_clr   (bus_dom_rst),
      .core_clr  (core_hit),
      .int_clr   (core_hit),
      .cfg_q     (cfg_q),
      .int_q     (int_q)
   );

   assign fifo_flush = core_hit;

   always_comb begin
      ctl_rdata                = '0;
      ctl_rdata[IDLE_FLAG_BIT] = mst_idle;
      ctl_rdata[REQ_BUS_BIT]   = req_bus_q;
      ctl_rdata[REQ_CORE_BIT]  = req_core_q;
   end

   // R5: no reset pulse while a transfer is still open
   a_r5_pulse_needs_idle: assert property (@(posedge hclk) disable iff (!hrst_n)
      $rose(bus_dom_rst) |-> mst_idle);

   // R4: flush always rides with the bus-domain reset
   a_r4_flush_with_bus_rst: assert property (@(posedge hclk) disable iff (!hrst_n)
      fifo_flush |-> bus_dom_rst);

endmodule

// File: tb/srst_ctrl_tb_top.sv
module srst_ctrl_tb_top;

   localparam int CFG_W = 16;
   localparam int INT_W = 8;
   localparam int HRST  = 4;

   typedef struct packed {
      logic [1:0]       bits;
      logic             flush;
      logic             phy;
      logic [7:0]       hits;
      logic [CFG_W-1:0] cfg;
      logic [INT_W-1:0] ints;
   } rec_t;

   logic hclk = 1'b0, phy_clk = 1'b0, hrst_n = 1'b0, phy_rst_n = 1'b0;
   logic ctl_wr_en = 1'b0;
   logic [1:0] ctl_wdata = '0;
   logic [31:0] ctl_rdata;
   logic cfg_wr_en = 1'b0;
   logic [CFG_W-1:0] cfg_wdata = '0, cfg_q;
   logic [INT_W-1:0] int_set = '0, int_q;
   logic mst_idle = 1'b1;
   logic mst_stop_req, bus_dom_rst, fifo_flush, phy_dom_rst, usb_abort, phy_access_ok;

   always #5 hclk = ~hclk;
   always #8 phy_clk = ~phy_clk;

   srst_ctrl #(.CFG_W(CFG_W), .INT_W(INT_W), .HRST_CYC(HRST)) dut_i (
      .hclk(hclk), .hrst_n(hrst_n), .phy_clk(phy_clk), .phy_rst_n(phy_rst_n),
      .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
      .int_set(int_set), .int_q(int_q), .mst_idle(mst_idle),
      .mst_stop_req(mst_stop_req), .bus_dom_rst(bus_dom_rst), .fifo_flush(fifo_flush),
      .phy_dom_rst(phy_dom_rst), .usb_abort(usb_abort), .phy_access_ok(phy_access_ok));

   int n_vec = 0, n_fail = 0, cyc = 0;
   logic running = 1'b0, done_flag = 1'b0;
   rec_t exp_q[$];
   logic [CFG_W-1:0] cfg_m;
   logic [INT_W-1:0] int_m;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   endtask

   always @(posedge hclk) begin
      cyc++;
      if (cyc == 150000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         finish_run();
      end
   end

   // monitor: collects what each request did and compares at completion
   logic [1:0] prev_bits = '0;
   logic acc_flush = 1'b0, acc_phy = 1'b0;
   int   acc_hits = 0;
   always @(negedge hclk) begin
      if (running) begin
         if (prev_bits == 2'b00 && ctl_rdata[1:0] != 2'b00) begin
            acc_flush = 1'b0; acc_phy = 1'b0; acc_hits = 0;
         end
         if (fifo_flush) acc_flush = 1'b1;
         if (phy_dom_rst) acc_phy = 1'b1;
         if (bus_dom_rst) acc_hits++;
         if (bus_dom_rst && !mst_idle) begin
            n_fail++;
            $display("FAIL R5 bus_dom_rst actual=1 expected=0 while master busy");
         end
         if (prev_bits != 2'b00 && ctl_rdata[1:0] == 2'b00) begin
            if (exp_q.size() == 0) begin
               chk("R9 unexpected completion", 1, 0);
            end else begin
               rec_t e;
               e = exp_q.pop_front();
               chk("R10 bits pending before clear", {30'b0, prev_bits}, {30'b0, e.bits});
               chk("R2/R4 fifo_flush seen", {31'b0, acc_flush}, {31'b0, e.flush});
               chk("R6 phy_dom_rst seen", {31'b0, acc_phy}, {31'b0, e.phy});
               chk("R2/R4 pulse length", acc_hits, {24'b0, e.hits});
               chk("R3/R4 cfg_q", {16'b0, cfg_q}, {16'b0, e.cfg});
               chk("R3/R4 int_q", {24'b0, int_q}, {24'b0, e.ints});
            end
         end
         prev_bits = ctl_rdata[1:0];
      end
   end

   task automatic ctl_write(input logic [1:0] v);
      @(negedge hclk); ctl_wr_en = 1'b1; ctl_wdata = v;
      @(negedge hclk); ctl_wr_en = 1'b0; ctl_wdata = '0;
   endtask

   task automatic wait_clear();
      for (int i = 0; i < 2000; i++) begin
         @(negedge hclk);
         if (ctl_rdata[1:0] == 2'b00) break;
      end
   endtask

   // driver: push the expected outcome, then run the request
   task automatic run_req(input logic [1:0] bits, input int busy, input logic [1:0] extra,
                          input logic [INT_W-1:0] pulse);
      rec_t e;
      logic core;
      core = bits[0];
      e.bits  = core ? bits : 2'b10;
      e.flush = core;
      e.phy   = core;
      e.hits  = 8'(HRST);
      e.cfg   = core ? (cfg_m & 16'h000F) : (cfg_m & ~16'h00F0);
      e.ints  = core ? '0 : (int_m | pulse);
      exp_q.push_back(e);
      mst_idle = 1'b0;
      ctl_write(bits);
      repeat (busy / 2) @(negedge hclk);
      chk("R5 stop request during drain", {31'b0, mst_stop_req}, 32'd1);
      chk("R7 idle flag low", {31'b0, ctl_rdata[31]}, 32'd0);
      if (core) begin
         chk("R6 phy reset done before master idle", {31'b0, acc_phy}, 32'd1);
         chk("R6 bit0 held until idle", {31'b0, ctl_rdata[0]}, 32'd1);
      end
      if (extra != 2'b00) ctl_write(extra);
      if (pulse != '0) begin
         @(negedge hclk); int_set = pulse;
         @(negedge hclk); int_set = '0;
      end
      repeat (busy / 2) @(negedge hclk);
      mst_idle = 1'b1;
      wait_clear();
      cfg_m = e.cfg;
      int_m = e.ints;
      if (core) begin
         chk("R8 access blocked at clear", {31'b0, phy_access_ok}, 32'd0);
         begin
            int n;
            n = 0;
            while (!phy_access_ok && n < 40) begin
               @(posedge phy_clk); n++;
               #1;
            end
            chk("R8 guard at least 3 phy clocks", {31'b0, (n >= 3) && (n < 40)}, 32'd1);
         end
      end
      chk("R9 no bit after completion", {30'b0, ctl_rdata[1:0]}, 32'd0);
      repeat (4) @(negedge hclk);
   endtask

   initial begin
      repeat (3) @(negedge hclk);
      hrst_n = 1'b1; phy_rst_n = 1'b1;
      repeat (2) @(negedge hclk);
      running = 1'b1;
      chk("R1 request bits", {30'b0, ctl_rdata[1:0]}, 32'd0);
      chk("R1 pulses idle", {28'b0, bus_dom_rst, fifo_flush, phy_dom_rst, usb_abort}, 32'd0);
      chk("R1 stop request", {31'b0, mst_stop_req}, 32'd0);
      chk("R1 phy access", {31'b0, phy_access_ok}, 32'd1);
      chk("R7 idle flag high", {31'b0, ctl_rdata[31]}, 32'd1);
      mst_idle = 1'b0; @(negedge hclk);
      chk("R7 idle flag follows", {31'b0, ctl_rdata[31]}, 32'd0);
      mst_idle = 1'b1;

      @(negedge hclk); cfg_wr_en = 1'b1; cfg_wdata = 16'hABCD;
      @(negedge hclk); cfg_wr_en = 1'b0; int_set = 8'h05;
      @(negedge hclk); int_set = '0;
      cfg_m = 16'hABCD; int_m = 8'h05;

      ctl_write(2'b00);
      repeat (5) @(negedge hclk);
      chk("R9 write of zero", {29'b0, mst_stop_req, ctl_rdata[1:0]}, 32'd0);

      run_req(2'b10, 8, 2'b00, 8'h40);     // R2 R3
      run_req(2'b01, 30, 2'b00, '0);        // R4 R6 R8
      @(negedge hclk); cfg_wr_en = 1'b1; cfg_wdata = 16'h5AF7;
      @(negedge hclk); cfg_wr_en = 1'b0; int_set = 8'h81;
      @(negedge hclk); int_set = '0;
      cfg_m = 16'h5AF7; int_m = 8'h81;
      run_req(2'b10, 24, 2'b01, 8'h02);     // R9 core write during bus reset ignored
      run_req(2'b01, 30, 2'b10, '0);        // R9 bus write during core reset ignored
      @(negedge hclk); cfg_wr_en = 1'b1; cfg_wdata = 16'hFFFF;
      @(negedge hclk); cfg_wr_en = 1'b0;
      cfg_m = 16'hFFFF;
      run_req(2'b11, 30, 2'b00, '0);        // R10 both bits

      repeat (10) @(negedge hclk);
      chk("R9 scoreboard drained", exp_q.size(), 0);
      finish_run();
   end

endmodule